// File: doc/BRIEF.md
# Shadowed SRAM with Store and Recall

This block is a byte-wide static memory that carries a full nonvolatile shadow copy of itself. Four active-low control inputs (chip enable, output enable, write enable and nonvolatile enable) are decoded each cycle into one of five operations: idle, read, write, store or recall. Reads and writes touch only the working array. A store copies the whole working array into the shadow array. A recall copies the whole shadow array back into the working array. Both transfers run as fixed-length sequences.

Store and recall start only when the controls move into their decoded pattern from some other pattern. Holding a pattern does not start the operation again. While a transfer runs, every control, address and data input is ignored and the data bus floats. A power-good input stands in for supply sensing. A store cannot start while it is low, and a store in progress is abandoned if it falls. The shadow array is never reset. After every reset an automatic recall refills the working array before the first external access is accepted.

The shared data bus is bidirectional. A separate `dq_oe` output reports when the block drives it.

Top module: `nvs_sram_shadow`

## Requirements
- R1: With nv_n=1, ce_n=0, oe_n=0, we_n=1 and busy low, dq_oe is 1 and dq carries the working word at addr in the same cycle, with no clock edge in between.
- R2: With nv_n=1, ce_n=0, we_n=0 and busy low, the word on dq is written at addr on the next rising edge. dq_oe stays 0 even when oe_n=0.
- R3: Moving into nv_n=0, ce_n=0, we_n=0, oe_n=1 from any other pattern, with pwr_ok=1 and busy low, starts a store. busy rises after that edge and stays high for exactly 2^ADDR_W cycles. Afterwards the shadow array equals the working array.
- R4: Moving into nv_n=0, ce_n=0, oe_n=0, we_n=1 from any other pattern, with busy low, starts a recall. busy stays high for 2^ADDR_W cycles. Afterwards the working array equals the shadow array.
- R5: Holding a store or recall pattern after its transfer ends does not start another transfer.
- R6: While busy is high, dq_oe is 0. Write, store and recall patterns applied during busy leave no trace, even though the patterns change during that time.
- R7: A store pattern entered while pwr_ok=0 starts nothing, and busy stays 0. Raising pwr_ok while the pattern is held starts nothing either, and the shadow array keeps its contents.
- R8: If pwr_ok is 0 in a store cycle, the store ends on that edge and busy falls. The shadow words already copied (addresses 0 upward) keep the new data, and the rest keep the old data. store_fail becomes 1 and stays 1.
- R9: A store that runs to completion clears store_fail.
- R10: During reset and for 2^ADDR_W cycles after it is released, busy is 1 while the working array is reloaded from the shadow array. The shadow array keeps its contents across reset. store_fail is 0 after reset.
- R11: In the cycle in which busy falls, the current control pattern takes effect at once. A read pattern drives dq without waiting for a further edge.
- R12: Every other pattern is idle: ce_n=1, or nv_n=0 with oe_n equal to we_n. An idle pattern drives nothing, writes nothing and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the shadow array is not cleared |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| nv_n | input | 1 | Nonvolatile-operation enable, active low |
| addr | input | ADDR_W | Word address |
| pwr_ok | input | 1 | Supply good; gates and aborts a store |
| dq | inout | DATA_W | Shared data bus |
| dq_oe | output | 1 | High while the block drives dq |
| busy | output | 1 | High while a store or recall transfer runs |
| store_fail | output | 1 | Sticky flag for an abandoned store |

## Verification
A read is due combinationally, so the bench samples dq and dq_oe 1 ns after it applies the controls on a falling edge. A write is due at the next rising edge and is read back on a later cycle. A store or recall is triggered at the first rising edge after its pattern is applied, so busy is first sampled at the following falling edge. From there the bench counts falling edges until busy drops and expects exactly 2^ADDR_W of them. The abort point is placed by counting cycles after the trigger: after J cycles with pwr_ok high, exactly J words are copied. The release from busy is sampled at the same falling edge where busy first reads low.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_READ,
    OP_WRITE,
    OP_STORE,
    OP_RECALL
  } nvs_op_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_STORE,
    SQ_RECALL
  } nvs_sq_e;

  // Control decode: all inputs active low.
  function automatic nvs_op_e decode_ctl(input logic nv_n, input logic ce_n,
                                         input logic oe_n, input logic we_n);
    nvs_op_e op;
    op = OP_IDLE;
    if (!ce_n) begin
      if (nv_n) begin
        if (!we_n)      op = OP_WRITE;
        else if (!oe_n) op = OP_READ;
      end else begin
        if (!we_n && oe_n)      op = OP_STORE;
        else if (we_n && !oe_n) op = OP_RECALL;
      end
    end
    return op;
  endfunction

  // True on the final word of a transfer.
  function automatic logic is_last(input int unsigned idx, input int unsigned depth);
    return idx == depth - 1;
  endfunction

endpackage

// File: rtl/nvs_mem.sv
module nvs_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nvs_decode.sv
module nvs_decode
  import nvs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    nv_n,
  input  logic    ce_n,
  input  logic    oe_n,
  input  logic    we_n,
  input  logic    pwr_ok,
  input  logic    busy,
  output nvs_op_e op,
  output logic    store_start,
  output logic    recall_start
);
  nvs_op_e prev_op;
  logic    entered;

  assign op = decode_ctl(nv_n, ce_n, oe_n, we_n);

  // The previous pattern is tracked even while busy, so a pattern held
  // across the end of a transfer does not count as a new entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_op <= OP_IDLE;
    else        prev_op <= op;
  end

  assign entered      = (op != prev_op) && !busy;
  assign store_start  = entered && (op == OP_STORE) && pwr_ok;
  assign recall_start = entered && (op == OP_RECALL);
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_start,
  input  logic              recall_start,
  input  logic              pwr_ok,
  output logic              busy,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic              copy_to_shadow,
  output logic              copy_to_work,
  output logic              store_done,
  output logic              store_abort,
  output logic              store_fail
);
  localparam int DEPTH = 1 << ADDR_W;

  nvs_sq_e           state;
  logic [ADDR_W-1:0] cnt;
  logic              last;

  assign busy           = (state != SQ_IDLE);
  assign xfer_addr      = cnt;
  assign last           = is_last(int'(cnt), DEPTH);
  assign copy_to_shadow = (state == SQ_STORE) && pwr_ok;
  assign store_abort    = (state == SQ_STORE) && !pwr_ok;
  assign copy_to_work   = (state == SQ_RECALL);
  assign store_done     = copy_to_shadow && last;

  // Reset enters the recall state: the working array is reloaded first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_RECALL;
      cnt   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          cnt <= '0;
          if (store_start)       state <= SQ_STORE;
          else if (recall_start) state <= SQ_RECALL;
        end
        SQ_STORE: begin
          if (store_abort || last) begin
            state <= SQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_RECALL: begin
          if (last) begin
            state <= SQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= SQ_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          store_fail <= 1'b0;
    else if (store_abort) store_fail <= 1'b1;
    else if (store_done)  store_fail <= 1'b0;
  end
endmodule

// File: rtl/nvs_sram_shadow.sv
module nvs_sram_shadow
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              nv_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pwr_ok,
  inout  wire  [DATA_W-1:0] dq,
  output logic              dq_oe,
  output logic              busy,
  output logic              store_fail
);
  localparam int DEPTH = 1 << ADDR_W;

  // Named internal events, visible to the bound checker.
  nvs_op_e           op;
  logic              store_start;
  logic              recall_start;
  logic              store_done;
  logic              store_abort;
  logic              ext_wr;
  logic              copy_to_shadow;
  logic              copy_to_work;
  logic [ADDR_W-1:0] xfer_addr;

  logic              work_we;
  logic [ADDR_W-1:0] work_waddr;
  logic [ADDR_W-1:0] work_raddr;
  logic [DATA_W-1:0] work_wdata;
  logic [DATA_W-1:0] work_rd;
  logic [DATA_W-1:0] shadow_rd;
  logic [DATA_W-1:0] dq_in;

  nvs_decode u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .nv_n        (nv_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .pwr_ok      (pwr_ok),
    .busy        (busy),
    .op          (op),
    .store_start (store_start),
    .recall_start(recall_start)
  );

  nvs_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .store_start   (store_start),
    .recall_start  (recall_start),
    .pwr_ok        (pwr_ok),
    .busy          (busy),
    .xfer_addr     (xfer_addr),
    .copy_to_shadow(copy_to_shadow),
    .copy_to_work  (copy_to_work),
    .store_done    (store_done),
    .store_abort   (store_abort),
    .store_fail    (store_fail)
  );

  // Working array: the external port when idle, the sequencer when busy.
  assign ext_wr     = !busy && (op == OP_WRITE);
  assign work_we    = ext_wr || copy_to_work;
  assign work_waddr = copy_to_work ? xfer_addr : addr;
  assign work_wdata = copy_to_work ? shadow_rd : dq_in;
  assign work_raddr = busy ? xfer_addr : addr;

  nvs_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_work (
    .clk  (clk),
    .we   (work_we),
    .waddr(work_waddr),
    .wdata(work_wdata),
    .raddr(work_raddr),
    .rdata(work_rd)
  );

  nvs_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
    .clk  (clk),
    .we   (copy_to_shadow),
    .waddr(xfer_addr),
    .wdata(work_rd),
    .raddr(xfer_addr),
    .rdata(shadow_rd)
  );

  // Bus control: drive only for a read pattern while no transfer runs.
  assign dq_oe = !busy && (op == OP_READ);
  assign dq    = dq_oe ? work_rd : {DATA_W{1'bz}};
  assign dq_in = dq;
endmodule

// File: rtl/nvs_sram_shadow_chk.sv
module nvs_sram_shadow_chk
  import nvs_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input logic    clk,
  input logic    rst_n,
  input logic    busy,
  input logic    dq_oe,
  input logic    store_fail,
  input logic    pwr_ok,
  input nvs_op_e op,
  input logic    ext_wr,
  input logic    store_start,
  input logic    recall_start,
  input logic    store_done,
  input logic    store_abort
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  AST_BUS_OFF_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dq_oe);                                                   // R6
  AST_NO_EXT_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ext_wr);                                                  // R6
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |-> !dq_oe);                                       // R2
  AST_STORE_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> pwr_ok);                                            // R7
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (store_start || recall_start) |=> busy);                            // R3
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STORE && $past(op) == OP_STORE) |-> !store_start);        // R5
  AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    store_abort |=> (store_fail && !busy));                             // R8
  AST_DONE_CLEARS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    store_done |=> !store_fail);                                        // R9
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= DEPTH);                                                  // R10
  AST_READ_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && op == OP_READ) |-> dq_oe);                          // R11
endmodule

bind nvs_sram_shadow nvs_sram_shadow_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .dq_oe       (dq_oe),
  .store_fail  (store_fail),
  .pwr_ok      (pwr_ok),
  .op          (op),
  .ext_wr      (ext_wr),
  .store_start (store_start),
  .recall_start(recall_start),
  .store_done  (store_done),
  .store_abort (store_abort)
);

// File: tb/tb_nvs_sram_shadow.sv
`timescale 1ns/1ps
module tb_nvs_sram_shadow;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, nv_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic pwr_ok = 1'b1;
  logic [DW-1:0] tb_dq = '0;
  logic tb_drv = 1'b0;
  wire  [DW-1:0] dq;
  logic dq_oe, busy, store_fail;

  int errs = 0;
  int checks = 0;
  logic [DW-1:0] work_m [N];
  logic [DW-1:0] shad_m [N];

  assign dq = tb_drv ? tb_dq : {DW{1'bz}};

  always #2 clk = ~clk;

  nvs_sram_shadow #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .nv_n(nv_n), .addr(addr), .pwr_ok(pwr_ok), .dq(dq), .dq_oe(dq_oe),
    .busy(busy), .store_fail(store_fail)
  );

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench's own view of the control patterns: 0 idle,1 read,2 write,3 store,4 recall.
  function automatic int kind_of(input logic nv, input logic ce, input logic oe, input logic we);
    if (ce) return 0;
    if (nv) return (!we) ? 2 : ((!oe) ? 1 : 0);
    if (oe == we) return 0;
    return (!we) ? 3 : 4;
  endfunction

  function automatic logic [DW-1:0] pat(input int a, input int seed);
    return DW'((a * 37 + seed * 11 + 5) & 8'hFF);
  endfunction

  task automatic ctl(input logic nv, input logic ce, input logic oe, input logic we);
    nv_n = nv; ce_n = ce; oe_n = oe; we_n = we;
  endtask

  task automatic go_idle();
    ctl(1, 1, 1, 1);
    tb_drv = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = AW'(a); tb_dq = d; tb_drv = 1'b1;
    ctl(1, 0, 1, 0);
    @(negedge clk);
    go_idle();
    work_m[a] = d;
  endtask

  task automatic do_read(input int a, input string tag);
    @(negedge clk);
    tb_drv = 1'b0; addr = AW'(a);
    ctl(1, 0, 0, 1);
    #1;
    chk(dq_oe === 1'b1 && dq === work_m[a], tag, int'(dq), int'(work_m[a]));
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < N; a++) do_read(a, tag);
    @(negedge clk);
    go_idle();
  endtask

  task automatic do_xfer(input bit is_store, input string tag);
    int n;
    @(negedge clk);
    go_idle();
    @(negedge clk);
    if (is_store) ctl(0, 0, 1, 0);
    else          ctl(0, 0, 0, 1);
    @(negedge clk);
    count_busy(n);
    chk(n == N, tag, n, N);
    for (int a = 0; a < N; a++) begin
      if (is_store) shad_m[a] = work_m[a];
      else          work_m[a] = shad_m[a];
    end
    go_idle();
  endtask

  task automatic do_reset(input string tag);
    int n;
    @(negedge clk);
    go_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b1 && store_fail === 1'b0 && dq_oe === 1'b0, tag,
        {busy, store_fail, dq_oe}, 3'b100);
    rst_n = 1'b1;
    count_busy(n);
    chk(n == N, tag, n, N);
    for (int a = 0; a < N; a++) work_m[a] = shad_m[a];
  endtask

  initial begin
    int n;
    int kind;
    // R10: reset state and automatic recall length
    do_reset("R10 reset recall");

    // R1 R2: exhaustive write and read back
    for (int a = 0; a < N; a++) do_write(a, pat(a, 1));
    read_all("R1 R2 readback");
    do_xfer(1, "R3 store length");

    // R12 R1 R2 R3 R4: sweep of all 16 control patterns
    for (int c = 0; c < 16; c++) begin
      logic nv, ce, oe, we;
      nv = c[3]; ce = c[2]; oe = c[1]; we = c[0];
      kind = kind_of(nv, ce, oe, we);
      @(negedge clk);
      go_idle();
      @(negedge clk);
      addr = AW'(c); tb_dq = DW'(8'hA0 + c); tb_drv = (kind != 1);
      ctl(nv, ce, oe, we);
      #1;
      chk(dq_oe === (kind == 1), "R12 R2 sweep drive", dq_oe, kind == 1);
      if (kind == 1) chk(dq === work_m[c], "R1 sweep read", dq, work_m[c]);
      @(negedge clk);
      chk(busy === (kind >= 3), "R12 R3 R4 sweep busy", busy, kind >= 3);
      if (kind == 2) work_m[c] = DW'(8'hA0 + c);
      if (kind >= 3) begin
        count_busy(n);
        chk(n == N, "R3 R4 sweep length", n, N);
        for (int a = 0; a < N; a++) begin
          if (kind == 3) shad_m[a] = work_m[a];
          else           work_m[a] = shad_m[a];
        end
      end
      go_idle();
    end
    read_all("R12 sweep contents");

    // R5: held store pattern does not restart
    @(negedge clk);
    ctl(0, 0, 1, 0);
    @(negedge clk);
    count_busy(n);
    chk(n == N, "R5 first store", n, N);
    for (int a = 0; a < N; a++) shad_m[a] = work_m[a];
    repeat (4) begin
      @(negedge clk);
      chk(busy === 1'b0, "R5 no retrigger", busy, 0);
    end
    go_idle();

    // R6 R11: inputs ignored during recall, read drives at release
    for (int a = 0; a < N; a++) do_write(a, pat(a, 2));
    @(negedge clk);
    ctl(0, 0, 0, 1);
    @(negedge clk);
    n = 1;
    addr = AW'(3); tb_dq = 8'hEE; tb_drv = 1'b1;
    ctl(1, 0, 0, 0);
    @(negedge clk); n++;
    chk(dq_oe === 1'b0 && busy === 1'b1, "R6 write ignored", dq_oe, 0);
    ctl(0, 0, 1, 0);
    @(negedge clk); n++;
    chk(dq_oe === 1'b0, "R6 store ignored", dq_oe, 0);
    tb_drv = 1'b0;
    ctl(1, 0, 0, 1);
    #1;
    chk(dq_oe === 1'b0, "R6 read held off", dq_oe, 0);
    while (busy && n < 1000) begin
      @(negedge clk);
      if (busy) n++;
    end
    chk(n == N, "R6 recall length", n, N);
    for (int a = 0; a < N; a++) work_m[a] = shad_m[a];
    chk(dq_oe === 1'b1 && dq === work_m[3], "R11 read at release", dq, work_m[3]);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R6 no late store", busy, 0);
    read_all("R6 contents after recall");

    // R7: store blocked by low power, not started when power returns
    for (int a = 0; a < N; a++) do_write(a, pat(a, 3));
    @(negedge clk);
    pwr_ok = 1'b0;
    ctl(0, 0, 1, 0);
    @(negedge clk);
    chk(busy === 1'b0, "R7 store blocked", busy, 0);
    pwr_ok = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(busy === 1'b0, "R7 no start on power", busy, 0);
    end
    go_idle();
    do_xfer(0, "R7 recall");
    read_all("R7 shadow kept");

    // R8 R9: abort after J words, partial shadow, sticky flag
    for (int a = 0; a < N; a++) do_write(a, pat(a, 4));
    @(negedge clk);
    ctl(0, 0, 1, 0);
    @(negedge clk);
    repeat (5) @(negedge clk);
    pwr_ok = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && store_fail === 1'b1, "R8 abort", {busy, store_fail}, 2'b01);
    for (int a = 0; a < 5; a++) shad_m[a] = work_m[a];
    pwr_ok = 1'b1;
    go_idle();
    repeat (2) @(negedge clk);
    chk(store_fail === 1'b1, "R8 flag sticky", store_fail, 1);
    for (int a = 0; a < N; a++) do_write(a, pat(a, 5));
    do_xfer(0, "R8 recall");
    read_all("R8 partial shadow");
    do_xfer(1, "R9 full store");
    chk(store_fail === 1'b0, "R9 flag cleared", store_fail, 0);

    // R10: shadow survives reset and is recalled
    for (int a = 0; a < N; a++) do_write(a, pat(a, 6));
    do_reset("R10 second reset");
    read_all("R10 restored");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule